// File: doc/BRIEF.md
# Bidirectional Port with Compare-Channel Override

An eight-pin general-purpose I/O port controlled through a small register bus. Software chooses each pin's direction, the level an output pin drives, and whether that pin's pad runs at reduced drive strength. A read-only view returns the pin levels after a two-flop synchronizer. That view stays live for output pins as well, so a driven level that disagrees with the level read back points to a short or an overload.

A timer's output-compare unit can take over single pins. While its enable for a pin is high, that pin is driven as an output with the timer's level. The stored direction bit stays as it was. When the enable drops, the pin returns to its stored direction and output latch. The synchronized pin levels also go to the timer's capture input, whatever the pin directions are.

Top module: `gpio_port_ovr`

## Requirements
- R1: After reset the direction, output-latch and reduced-drive registers read 0, and `pad_oe` and `pad_weak` are all 0.
- R2: A write to address 2 (direction) stores `bus_wdata` and reads back from the next cycle. With no override, `pad_oe` equals the stored direction, where 1 means output.
- R3: A write to address 3 (reduced drive) stores `bus_wdata` and reads back. `pad_weak` equals the stored value, where 1 selects reduced strength.
- R4: Address 1 (pin input) reads the synchronized pin levels. A write to it changes no register and does not change what any address reads.
- R5: A change on `pin_in` reaches the address-1 read and `tmr_cap_in` after exactly two rising clock edges, and not after one.
- R6: While `tmr_oc_en[i]` is 1, `pad_oe[i]` is 1 and `pad_out[i]` equals `tmr_oc_val[i]`. The stored direction bit is unchanged and still reads back.
- R7: When `tmr_oc_en[i]` returns to 0, `pad_oe[i]` follows the stored direction bit again and `pad_out[i]` follows the output latch.
- R8: A write to address 0 stores the output latch. With no override, `pad_out` equals the latch.
- R9: An address-0 read returns, for each pin, the latch bit where the direction bit is 1 and the synchronized pin level where it is 0.
- R10: `tmr_cap_in` equals the synchronized pin levels for every pin, whatever the direction bits and overrides are.
- R11: No register changes unless `bus_we` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select: 0 latch, 1 pin input, 2 direction, 3 reduced drive |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 8 | Combinational read data for the selected register |
| pin_in | input | 8 | Raw pad input levels |
| tmr_oc_en | input | 8 | Per-pin output-compare override enable |
| tmr_oc_val | input | 8 | Per-pin level driven while overridden |
| pad_oe | output | 8 | Pad output enable |
| pad_out | output | 8 | Pad output level |
| pad_weak | output | 8 | Pad reduced-drive select |
| tmr_cap_in | output | 8 | Synchronized pin levels to the timer capture input |

## Verification
Assertions check several rules on every cycle: override pins are always enabled as outputs, pins without an override follow the stored direction and latch, direction writes land in the next cycle, writes to the input address leave all registers stable, and the synchronizer output matches the pin level from two cycles earlier. Only the bench scenarios can show the full read data seen at the bus. This covers the per-bit mix of latch and pin on address 0, exact one-edge against two-edge sampling from the bus side, and direction bits that survive an override and its removal.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    REG_DATA  = 2'd0,
    REG_PINS  = 2'd1,
    REG_DIR   = 2'd2,
    REG_DRIVE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= pin_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign sync_o = chain[STAGES-1];

  // warm-up counter so the latency check never looks back into reset
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_q <= '0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  if (STAGES == 2) begin : g_lat_chk
    p_sync_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q == 2'd2) |-> (sync_o == $past(pin_i, 2)));
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  reg_sel_e         sel,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] latch_q,
  output logic [WIDTH-1:0] drive_q
);
  logic wr_dir, wr_latch, wr_drive, wr_pins;
  assign wr_dir   = wr_en && (sel == REG_DIR);
  assign wr_latch = wr_en && (sel == REG_DATA);
  assign wr_drive = wr_en && (sel == REG_DRIVE);
  assign wr_pins  = wr_en && (sel == REG_PINS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      latch_q <= '0;
      drive_q <= '0;
    end else begin
      if (wr_dir)   dir_q   <= wdata;
      if (wr_latch) latch_q <= wdata;
      if (wr_drive) drive_q <= wdata;
    end
  end

  p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> (dir_q == $past(wdata)));
  p_pins_ro_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pins |=> ($stable(dir_q) && $stable(latch_q) && $stable(drive_q)));
  p_dir_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir |=> $stable(dir_q));
  p_no_we_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(dir_q) && $stable(latch_q) && $stable(drive_q)));
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] latch_q,
  input  logic [WIDTH-1:0] oc_en,
  input  logic [WIDTH-1:0] oc_val,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_out
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    assign pad_oe[i]  = oc_en[i] | dir_q[i];
    assign pad_out[i] = oc_en[i] ? oc_val[i] : latch_q[i];
  end
endmodule

// File: rtl/gpio_port_ovr.sv
module gpio_port_ovr
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  input  logic             bus_we,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] pin_in,
  input  logic [WIDTH-1:0] tmr_oc_en,
  input  logic [WIDTH-1:0] tmr_oc_val,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_weak,
  output logic [WIDTH-1:0] tmr_cap_in
);
  reg_sel_e         sel;
  logic [WIDTH-1:0] dir_q, latch_q, drive_q, pins_sync;

  assign sel = reg_sel_e'(bus_addr);

  // latch bit for output-direction pins, synchronized level for inputs
  function automatic logic [WIDTH-1:0] data_view(
    input logic [WIDTH-1:0] dir, input logic [WIDTH-1:0] lat, input logic [WIDTH-1:0] pins);
    return (dir & lat) | (~dir & pins);
  endfunction

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_in), .sync_o(pins_sync));

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .sel(sel), .wdata(bus_wdata),
    .dir_q(dir_q), .latch_q(latch_q), .drive_q(drive_q));

  gpio_pad_ctl #(.WIDTH(WIDTH)) u_pad (
    .dir_q(dir_q), .latch_q(latch_q), .oc_en(tmr_oc_en), .oc_val(tmr_oc_val),
    .pad_oe(pad_oe), .pad_out(pad_out));

  assign pad_weak   = drive_q;
  assign tmr_cap_in = pins_sync;

  always_comb begin
    unique case (sel)
      REG_DATA:  bus_rdata = data_view(dir_q, latch_q, pins_sync);
      REG_PINS:  bus_rdata = pins_sync;
      REG_DIR:   bus_rdata = dir_q;
      REG_DRIVE: bus_rdata = drive_q;
      default:   bus_rdata = '0;
    endcase
  end

  p_oc_forces_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((tmr_oc_en & ~pad_oe) == '0));
  p_oc_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((tmr_oc_en & (pad_out ^ tmr_oc_val)) == '0));
  p_oe_follow_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((~tmr_oc_en & (pad_oe ^ dir_q)) == '0));
  p_out_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((~tmr_oc_en & (pad_out ^ latch_q)) == '0));
endmodule

// File: tb/gpio_port_ovr_tb.sv
module gpio_port_ovr_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = '0, tmr_oc_en = '0, tmr_oc_val = '0;
  logic [7:0] pad_oe, pad_out, pad_weak, tmr_cap_in;

  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_port_ovr u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .tmr_oc_en(tmr_oc_en), .tmr_oc_val(tmr_oc_val), .pad_oe(pad_oe),
    .pad_out(pad_out), .pad_weak(pad_weak), .tmr_cap_in(tmr_cap_in));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic we);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = we;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // bench model: per pin select, override wins
  function automatic logic [7:0] m_oe(input logic [7:0] dir, input logic [7:0] en);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = en[i] ? 1'b1 : dir[i];
    return r;
  endfunction
  function automatic logic [7:0] m_out(input logic [7:0] lat, input logic [7:0] en, input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = en[i] ? v[i] : lat[i];
    return r;
  endfunction
  function automatic logic [7:0] m_read0(input logic [7:0] dir, input logic [7:0] lat, input logic [7:0] p);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = dir[i] ? lat[i] : p[i];
    return r;
  endfunction

  initial begin
    #1ms;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=00 expected=01");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [7:0] dir, lat, drv, en, val, pins;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd2, r); check("R1 dir", r, 8'h00);
    rd(2'd3, r); check("R1 drive", r, 8'h00);
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 pad_weak", pad_weak, 8'h00);
    rd(2'd0, r); check("R1 latch/pins", r, 8'h00);

    // R5 synchronizer latency: one edge not enough, two edges are
    @(negedge clk); pin_in = 8'hA5;
    @(negedge clk); rd(2'd1, r); check("R5 one edge", r, 8'h00);
    check("R5 cap one edge", tmr_cap_in, 8'h00);
    @(negedge clk); rd(2'd1, r); check("R5 two edges", r, 8'hA5);
    check("R10 cap", tmr_cap_in, 8'hA5);

    // R2/R8/R9 directed
    wr(2'd0, 8'h3C, 1'b1);
    wr(2'd2, 8'h0F, 1'b1);
    rd(2'd2, r); check("R2 dir rb", r, 8'h0F);
    check("R2 pad_oe", pad_oe, 8'h0F);
    check("R8 pad_out", pad_out, 8'h3C);
    rd(2'd0, r); check("R9 mixed read", r, 8'hAC);

    // R3
    wr(2'd3, 8'h81, 1'b1);
    rd(2'd3, r); check("R3 drive rb", r, 8'h81);
    check("R3 pad_weak", pad_weak, 8'h81);

    // R4 write to input address ignored
    wr(2'd1, 8'h5A, 1'b1);
    rd(2'd1, r); check("R4 pins", r, 8'hA5);
    rd(2'd2, r); check("R4 dir", r, 8'h0F);
    rd(2'd3, r); check("R4 drive", r, 8'h81);
    rd(2'd0, r); check("R4 data", r, 8'hAC);

    // R11 strobe low
    wr(2'd2, 8'hF0, 1'b0);
    rd(2'd2, r); check("R11 dir", r, 8'h0F);

    // R6 override, R7 revert
    @(negedge clk); tmr_oc_en = 8'hF0; tmr_oc_val = 8'h50;
    #1;
    check("R6 pad_oe", pad_oe, 8'hFF);
    check("R6 pad_out", pad_out, 8'h5C);
    rd(2'd2, r); check("R6 dir kept", r, 8'h0F);
    @(negedge clk); @(negedge clk); tmr_oc_en = 8'h00;
    #1;
    check("R7 pad_oe", pad_oe, 8'h0F);
    check("R7 pad_out", pad_out, 8'h3C);

    // random mix
    for (int k = 0; k < 300; k++) begin
      dir = 8'($urandom); lat = 8'($urandom); drv = 8'($urandom);
      en = 8'($urandom); val = 8'($urandom); pins = 8'($urandom);
      @(negedge clk); pin_in = pins;
      wr(2'd2, dir, 1'b1);
      wr(2'd0, lat, 1'b1);
      wr(2'd3, drv, 1'b1);
      tmr_oc_en = en; tmr_oc_val = val;
      rd(2'd2, r); check("R6 rnd dir", r, dir);
      rd(2'd3, r); check("R3 rnd", r, drv);
      check("R3 rnd weak", pad_weak, drv);
      rd(2'd1, r); check("R4 rnd pins", r, pins);
      check("R10 rnd cap", tmr_cap_in, pins);
      rd(2'd0, r); check("R9 rnd", r, m_read0(dir, lat, pins));
      check("R6 rnd oe", pad_oe, m_oe(dir, en));
      check("R8 rnd out", pad_out, m_out(lat, en, val));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule